// File: doc/BRIEF.md
# Indexed Memory Move Sequencer

This block runs the data-memory side of three multi-word byte-move instructions. Each instruction copies one byte from a source location to a destination location. The source is always found by adding a 7-bit offset, carried in the instruction, to a 14-bit frame pointer. The destination is one of three things: a 12-bit absolute address, a 14-bit absolute address, or a second frame-pointer-relative location.

The block takes one instruction word per clock. It drives a single memory port with an address, a read strobe and a write strobe. Read data must come back in the same cycle as the read strobe. An external address classifier raises two flags for the address currently on the port: one for indirect-access registers and one for protected registers. The block uses these flags to replace the source byte with zero or to drop the write, and the instruction still takes its normal number of cycles. The enclosing core fetches the words and advances the program counter. No status flags are changed.

Top module: `idx_move_seq`

## Requirements
- R1: After reset, and after a reset asserted in the middle of an instruction, the block is idle. `mem_rd`, `mem_wr` and `done` are low, and the next word is decoded as a first word.
- R2: Short absolute form. The first word has bits 15:7 = 111010110 and the source offset in bits 6:0. The second word carries the destination in bits 11:0, zero-extended to 14 bits. The source read happens in the first-word cycle. The write and `done` happen in the second-word cycle.
- R3: Long absolute form. The first word is exactly 0x0062 and causes no memory access. The second word carries the source offset in bits 8:2 and destination bits 13:12 in bits 1:0; the source is read in that cycle. The third word carries destination bits 11:0; the write and `done` happen in that cycle.
- R4: Indexed form. The first word has bits 15:7 = 111010111 and the source offset in bits 6:0; the source is read in that cycle. The second word carries a destination offset in bits 6:0. The destination is the frame pointer plus that offset, and it is written with `done` in that cycle.
- R5: A source read while `addr_indirect` is high stores 00h as the byte to be written.
- R6: In the indexed form, a destination with `addr_indirect` high gets no write strobe, and `done` still rises in the final cycle.
- R7: In the long and indexed forms, a destination with `addr_protected` high gets no write strobe, and `done` still rises in the final cycle.
- R8: Frame-pointer-plus-offset sums wrap modulo 2^14.
- R9: A cycle with `iw_valid` low consumes no word. It raises no strobe and no `done`, and the instruction resumes on the next valid word.
- R10: A first word that matches none of the three forms produces no strobe and leaves the block idle.
- R11: `mem_rd` and `mem_wr` are never high together. `wr_data` is the byte captured by the instruction's read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iw_valid | input | 1 | Instruction word present this cycle |
| iw_data | input | 16 | Instruction word |
| frame_ptr | input | 14 | Frame pointer used as the index base |
| rd_data | input | 8 | Read data for the address on `mem_addr`, same cycle |
| addr_indirect | input | 1 | `mem_addr` is an indirect-access register |
| addr_protected | input | 1 | `mem_addr` is a protected register |
| mem_addr | output | 14 | Data memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| wr_data | output | 8 | Write data |
| done | output | 1 | Final cycle of an instruction |

## Verification
Each of the three forms is driven with ordinary addresses and compared against per-cycle expected strobes, addresses and data. This separates the forms by when they read, when they write, and which word fields they take. Frame pointers near the top of the space show whether the sums wrap or spill. Sources in the indirect window show whether the read byte is replaced by zero. Destinations in the indirect and protected windows show that the write is dropped per form while `done` keeps its timing. Word bubbles, unmatched opcodes and a reset in mid-instruction check that no word is consumed or decoded out of turn.

// File: rtl/idx_move_pkg.sv
package idx_move_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ABS_FIN,
      ST_LONG_SRC,
      ST_LONG_FIN,
      ST_IDX_FIN
   } seq_state_e;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_ABS,
      OP_LONG,
      OP_IDX
   } op_kind_e;

   typedef enum logic [1:0] {
      WCHK_NONE,
      WCHK_PROT,
      WCHK_PROT_IND
   } wr_check_e;

   localparam logic [8:0]  OPC_ABS   = 9'b1110_1011_0;
   localparam logic [8:0]  OPC_IDX   = 9'b1110_1011_1;
   localparam logic [15:0] LONG_WORD = 16'h0062;

endpackage

// File: rtl/idx_move_dec.sv
module idx_move_dec
   import idx_move_pkg::*;
#(
   parameter int IW      = 16,
   parameter int OFS_W   = 7,
   parameter bit EN_LONG = 1'b1
) (
   input  logic [IW-1:0] word,
   output op_kind_e      kind
);

   logic long_hit;

   generate
      if (EN_LONG) begin : g_long
         assign long_hit = (word == IW'(LONG_WORD));
      end else begin : g_no_long
         assign long_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      kind = OP_NONE;
      if (word[IW-1:OFS_W] == OPC_ABS)      kind = OP_ABS;
      else if (word[IW-1:OFS_W] == OPC_IDX) kind = OP_IDX;
      else if (long_hit)                    kind = OP_LONG;
   end

endmodule

// File: rtl/idx_move_agen.sv
module idx_move_agen #(
   parameter int AW    = 14,
   parameter int OFS_W = 7
) (
   input  logic [AW-1:0]    base,
   input  logic [OFS_W-1:0] ofs,
   output logic [AW-1:0]    sum
);

   assign sum = base + AW'(ofs);

endmodule

// File: rtl/idx_move_gate.sv
module idx_move_gate
   import idx_move_pkg::*;
(
   input  wr_check_e mode,
   input  logic      prot,
   input  logic      ind,
   output logic      allow
);

   always_comb begin
      unique case (mode)
         WCHK_PROT:     allow = ~prot;
         WCHK_PROT_IND: allow = ~(prot | ind);
         default:       allow = 1'b1;
      endcase
   end

endmodule

// File: rtl/idx_move_seq.sv
module idx_move_seq
   import idx_move_pkg::*;
#(
   parameter int AW          = 14,
   parameter int DW          = 8,
   parameter int IW          = 16,
   parameter int OFS_W       = 7,
   parameter int SHORT_DST_W = 12,
   parameter bit EN_LONG     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          iw_valid,
   input  logic [IW-1:0] iw_data,
   input  logic [AW-1:0] frame_ptr,
   input  logic [DW-1:0] rd_data,
   input  logic          addr_indirect,
   input  logic          addr_protected,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] wr_data,
   output logic          done
);

   localparam int HI_W = AW - SHORT_DST_W;

   generate
      if (IW != 9 + OFS_W) begin : g_bad_iw
         $error("opcode field needs IW == 9 + OFS_W");
      end
      if (HI_W < 1) begin : g_bad_hi
         $error("AW must exceed SHORT_DST_W");
      end
      if (7 + OFS_W + HI_W > IW) begin : g_bad_long
         $error("long-form second word does not fit IW");
      end
      if (4 + SHORT_DST_W > IW) begin : g_bad_short
         $error("short destination does not fit IW");
      end
   endgenerate

   seq_state_e          state_q, state_d;
   logic [DW-1:0]       byte_q;
   logic [HI_W-1:0]     hi_q;
   op_kind_e            kind;
   logic [OFS_W-1:0]    ofs_sel;
   logic [AW-1:0]       idx_addr;
   wr_check_e           wchk;
   logic                wr_req;
   logic                wr_allow;

   idx_move_dec #(.IW(IW), .OFS_W(OFS_W), .EN_LONG(EN_LONG)) u_dec (
      .word (iw_data),
      .kind (kind)
   );

   idx_move_agen #(.AW(AW), .OFS_W(OFS_W)) u_agen (
      .base (frame_ptr),
      .ofs  (ofs_sel),
      .sum  (idx_addr)
   );

   idx_move_gate u_gate (
      .mode  (wchk),
      .prot  (addr_protected),
      .ind   (addr_indirect),
      .allow (wr_allow)
   );

   always_comb begin
      state_d  = state_q;
      ofs_sel  = iw_data[OFS_W-1:0];
      mem_addr = '0;
      mem_rd   = 1'b0;
      wr_req   = 1'b0;
      done     = 1'b0;
      wchk     = WCHK_NONE;
      unique case (state_q)
         ST_IDLE: begin
            if (iw_valid) begin
               unique case (kind)
                  OP_ABS: begin
                     mem_addr = idx_addr;
                     mem_rd   = 1'b1;
                     state_d  = ST_ABS_FIN;
                  end
                  OP_IDX: begin
                     mem_addr = idx_addr;
                     mem_rd   = 1'b1;
                     state_d  = ST_IDX_FIN;
                  end
                  OP_LONG: state_d = ST_LONG_SRC;
                  default: state_d = ST_IDLE;
               endcase
            end
         end
         ST_LONG_SRC: begin
            ofs_sel = iw_data[HI_W+OFS_W-1:HI_W];
            if (iw_valid) begin
               mem_addr = idx_addr;
               mem_rd   = 1'b1;
               state_d  = ST_LONG_FIN;
            end
         end
         ST_ABS_FIN: begin
            if (iw_valid) begin
               mem_addr = {{HI_W{1'b0}}, iw_data[SHORT_DST_W-1:0]};
               wr_req   = 1'b1;
               done     = 1'b1;
               state_d  = ST_IDLE;
            end
         end
         ST_LONG_FIN: begin
            wchk = WCHK_PROT;
            if (iw_valid) begin
               mem_addr = {hi_q, iw_data[SHORT_DST_W-1:0]};
               wr_req   = 1'b1;
               done     = 1'b1;
               state_d  = ST_IDLE;
            end
         end
         ST_IDX_FIN: begin
            wchk = WCHK_PROT_IND;
            if (iw_valid) begin
               mem_addr = idx_addr;
               wr_req   = 1'b1;
               done     = 1'b1;
               state_d  = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign mem_wr  = wr_req & wr_allow;
   assign wr_data = byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         byte_q  <= '0;
         hi_q    <= '0;
      end else begin
         state_q <= state_d;
         if (mem_rd) byte_q <= addr_indirect ? '0 : rd_data;
         if (state_q == ST_LONG_SRC && iw_valid) hi_q <= iw_data[HI_W-1:0];
      end
   end

endmodule

// File: rtl/idx_move_seq_chk.sv
module idx_move_seq_chk #(
   parameter int AW          = 14,
   parameter int DW          = 8,
   parameter int SHORT_DST_W = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          iw_valid,
   input logic [DW-1:0] rd_data,
   input logic          addr_indirect,
   input logic          addr_protected,
   input logic [AW-1:0] mem_addr,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic [DW-1:0] wr_data,
   input logic          done
);

   a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   a_r11_byte_captured: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !addr_indirect) |=> (wr_data == $past(rd_data)));

   a_r5_indirect_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && addr_indirect) |=> (wr_data == '0));

   a_r2_write_in_final: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> done);

   a_r1_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !mem_wr));

   a_r4_read_then_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   a_r9_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      !iw_valid |-> (!mem_rd && !mem_wr && !done));

   a_r7_protected_write_short: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && addr_protected) |-> (mem_addr[AW-1:SHORT_DST_W] == '0));

endmodule

bind idx_move_seq idx_move_seq_chk #(.AW(AW), .DW(DW), .SHORT_DST_W(SHORT_DST_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .iw_valid       (iw_valid),
   .rd_data        (rd_data),
   .addr_indirect  (addr_indirect),
   .addr_protected (addr_protected),
   .mem_addr       (mem_addr),
   .mem_rd         (mem_rd),
   .mem_wr         (mem_wr),
   .wr_data        (wr_data),
   .done           (done)
);

// File: tb/idx_move_seq_tb.sv
module idx_move_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iw_valid = 1'b0;
   logic [15:0] iw_data = '0;
   logic [13:0] frame_ptr = '0;
   logic [7:0]  rd_data;
   logic        addr_indirect, addr_protected;
   logic [13:0] mem_addr;
   logic        mem_rd, mem_wr, done;
   logic [7:0]  wr_data;

   int nchk = 0;
   int nfail = 0;

   always #5 clk = ~clk;

   idx_move_seq u_dut (
      .clk (clk), .rst_n (rst_n), .iw_valid (iw_valid), .iw_data (iw_data),
      .frame_ptr (frame_ptr), .rd_data (rd_data), .addr_indirect (addr_indirect),
      .addr_protected (addr_protected), .mem_addr (mem_addr), .mem_rd (mem_rd),
      .mem_wr (mem_wr), .wr_data (wr_data), .done (done)
   );

   function automatic logic [7:0] data_of(input logic [13:0] a);
      if (a == 14'h0085) return 8'h33;
      return a[7:0] ^ {2'b10, a[13:8]};
   endfunction

   // memory model and address classifier
   assign rd_data        = data_of(mem_addr);
   assign addr_indirect  = (mem_addr[13:3] == 11'h7FC);
   assign addr_protected = (mem_addr[13:2] == 12'hFFF);

   typedef struct packed {
      logic [1:0]  kind;     // 0 short absolute, 1 long absolute, 2 indexed
      logic [13:0] fp;
      logic [6:0]  zs;
      logic [13:0] dst;      // destination address, or destination offset for indexed
      logic [13:0] exp_src;
      logic [13:0] exp_dst;
      logic        exp_we;
      logic        exp_zero;
      logic [2:0]  tag;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{2'd2, 14'h0080, 7'h05, 14'h0006, 14'h0085, 14'h0086, 1'b1, 1'b0, 3'd2},
      '{2'd0, 14'h0100, 7'h7F, 14'h0ABC, 14'h017F, 14'h0ABC, 1'b1, 1'b0, 3'd0},
      '{2'd1, 14'h2080, 7'h05, 14'h2000, 14'h2085, 14'h2000, 1'b1, 1'b0, 3'd1},
      '{2'd2, 14'h3FF0, 7'h7F, 14'h0020, 14'h006F, 14'h0010, 1'b1, 1'b0, 3'd6},
      '{2'd0, 14'h3F80, 7'h62, 14'h0123, 14'h3FE2, 14'h0123, 1'b1, 1'b1, 3'd3},
      '{2'd2, 14'h3F90, 7'h01, 14'h0055, 14'h3F91, 14'h3FE5, 1'b0, 1'b0, 3'd4},
      '{2'd1, 14'h0000, 7'h10, 14'h3FFD, 14'h0010, 14'h3FFD, 1'b0, 1'b0, 3'd5},
      '{2'd2, 14'h3F90, 7'h01, 14'h006E, 14'h3F91, 14'h3FFE, 1'b0, 1'b0, 3'd5},
      '{2'd0, 14'h0000, 7'h00, 14'h0FFF, 14'h0000, 14'h0FFF, 1'b1, 1'b0, 3'd0},
      '{2'd1, 14'h3FFF, 7'h7F, 14'h1234, 14'h007E, 14'h1234, 1'b1, 1'b0, 3'd6}
   };

   function automatic string tag_name(input logic [2:0] t);
      case (t)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         3'd4: return "R6";
         3'd5: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [15:0] w, input logic [13:0] fp);
      @(posedge clk);
      #1;
      iw_valid  = v;
      iw_data   = w;
      frame_ptr = fp;
      @(negedge clk);
   endtask

   task automatic quiet(input string req, input string what);
      chk(!mem_rd && !mem_wr && !done, req, what, {13'b0, mem_rd, mem_wr, done}, 16'h0);
   endtask

   task automatic run_vec(input vec_t v);
      logic [15:0] w [3];
      int n;
      string rq;
      logic [7:0] exp_byte;
      rq = tag_name(v.tag);
      exp_byte = v.exp_zero ? 8'h00 : data_of(v.exp_src);
      case (v.kind)
         2'd0: begin
            w[0] = {9'b111010110, v.zs}; w[1] = {4'hF, v.dst[11:0]}; w[2] = '0; n = 2;
         end
         2'd1: begin
            w[0] = 16'h0062; w[1] = {4'hF, 3'b000, v.zs, v.dst[13:12]};
            w[2] = {4'hF, v.dst[11:0]}; n = 3;
         end
         default: begin
            w[0] = {9'b111010111, v.zs}; w[1] = {4'hF, 5'b0, v.dst[6:0]}; w[2] = '0; n = 2;
         end
      endcase
      for (int i = 0; i < n; i++) begin
         bit is_read;
         drive(1'b1, w[i], v.fp);
         is_read = (v.kind == 2'd1) ? (i == 1) : (i == 0);
         if (i == n - 1) begin
            chk(done, rq, "done in final cycle", {15'b0, done}, 16'h1);
            chk(mem_wr == v.exp_we, rq, "write strobe", {15'b0, mem_wr}, {15'b0, v.exp_we});
            chk(!mem_rd, "R11", "no read with write", {15'b0, mem_rd}, 16'h0);
            if (v.exp_we) begin
               chk(mem_addr == v.exp_dst, rq, "dest address", {2'b0, mem_addr}, {2'b0, v.exp_dst});
               chk(wr_data == exp_byte, rq, "write data", {8'b0, wr_data}, {8'b0, exp_byte});
            end
         end else if (is_read) begin
            chk(mem_rd && !mem_wr && !done, rq, "read strobe", {13'b0, mem_rd, mem_wr, done}, 16'h4);
            chk(mem_addr == v.exp_src, rq, "source address", {2'b0, mem_addr}, {2'b0, v.exp_src});
         end else begin
            quiet("R3", "long first word has no access");
         end
      end
      drive(1'b0, 16'h0, v.fp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      quiet("R1", "outputs after reset");

      for (int k = 0; k < NV; k++) run_vec(VEC[k]);

      // R9: bubble between the two words of an indexed move
      drive(1'b1, {9'b111010111, 7'h05}, 14'h0080);
      chk(mem_rd && mem_addr == 14'h0085, "R9", "read before bubble", {2'b0, mem_addr}, 16'h0085);
      drive(1'b0, 16'hF006, 14'h0080);
      quiet("R9", "bubble cycle");
      drive(1'b1, 16'hF006, 14'h0080);
      chk(mem_wr && done && mem_addr == 14'h0086 && wr_data == 8'h33, "R9", "write after bubble",
          {wr_data, 7'b0, mem_wr}, 16'h3301);
      drive(1'b0, 16'h0, 14'h0080);

      // R10: unmatched first words do nothing and leave the block idle
      drive(1'b1, 16'hF0AB, 14'h0080);
      quiet("R10", "unmatched word F0AB");
      drive(1'b1, 16'hEA55, 14'h0080);
      quiet("R10", "unmatched word EA55");
      drive(1'b1, {9'b111010110, 7'h05}, 14'h0080);
      chk(mem_rd && mem_addr == 14'h0085, "R10", "decode after unmatched", {2'b0, mem_addr}, 16'h0085);
      drive(1'b1, 16'hF200, 14'h0080);
      chk(mem_wr && done && mem_addr == 14'h0200, "R10", "short write after unmatched",
          {2'b0, mem_addr}, 16'h0200);
      drive(1'b0, 16'h0, 14'h0080);

      // R1: reset in the middle of an instruction
      drive(1'b1, {9'b111010110, 7'h05}, 14'h0080);
      @(posedge clk);
      #1 iw_valid = 1'b0; rst_n = 1'b0;
      @(posedge clk);
      #1 rst_n = 1'b1;
      drive(1'b1, 16'hF123, 14'h0080);
      quiet("R1", "word after mid-instruction reset");
      drive(1'b0, 16'h0, 14'h0080);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule